// File: doc/BRIEF.md
# Bus Cycle State Tracker

This block passively follows a multiplexed 20-bit address/data bus of an 8088-class processor. It works from sampled pin values alone and never drives the bus. Every input is sampled on the rising edge of the processor clock. From the three bus status lines it decodes the kind of bus cycle in progress. It rebuilds the address-latch strobe from the status history, because no latch-enable pin is available. It holds the latched address. From the status history and the READY line it rebuilds the processor's T-states.

Wait states come from a two-sample READY rule. The rule looks at the current READY sample and the one taken on the clock before it. When the data phase ends, the tracker captures the low byte of the bus and raises a one-clock valid pulse. During the active part of a cycle, it also reports which segment register the two segment status bits select.

All outputs are registered. Each output reflects the sample taken on the most recent rising clock edge. A trace recorder or a cycle-accurate comparison engine would consume these outputs.

Top module: `bus_cycle_tracker`

## Requirements
- R1: A synchronous active-high reset clears every output to zero except the following two. `t_state` reads TI and `cyc_kind` reads passive (111). The tracker also treats the previous status sample as passive and the previous READY sample as high.
- R2: `cyc_kind` shows the status lines of the latest sample, decoded as S2..S0. The codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write and 111 passive. `addr_strobe` is high for one clock after a sample whose status is active while the previous sample's status was passive. It is low otherwise, including while an active status persists.
- R3: On a strobe clock, `addr_hold` takes the 20-bit bus value of that sample. It keeps that value unchanged until the next strobe.
- R4: `t_state` is encoded as TI=0, T1=1, T2=2, T3=3, Tw=4, T4=5. A strobe sample sets T1 whatever the current state is. Without a strobe, T1 always goes to T2 and T2 always goes to T3.
- R5: From T3, the tracker goes to Tw when READY is low in the current sample or was low in the previous sample. Otherwise it goes to T4.
- R6: In Tw, the tracker goes to T4 when the previous READY sample was high. Otherwise it stays in Tw.
- R7: T4 is followed by TI, and TI lasts until the next strobe.
- R8: `data_valid` pulses for one clock, with `data_byte` set to bus bits 7:0 of that sample, in two cases. The first is a T2-to-T3 step whose current READY is high. The second is a Tw-to-T4 step. `data_byte` holds its value otherwise.
- R9: `seg_sel` is one-hot while the new state is T2, T3, Tw or T4. With the segment bits read as {S4,S3}, 00 sets bit 0 (extra segment), 01 sets bit 1 (stack), 10 sets bit 2 (code) and 11 sets bit 3 (data). It is zero in TI and T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; every sample is taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad | input | 20 | Multiplexed address/data lines |
| bus_stat | input | 3 | Status lines S2..S0 |
| bus_ready | input | 1 | READY line |
| bus_seg | input | 2 | Segment status bits {S4,S3} |
| addr_strobe | output | 1 | Rebuilt address-latch strobe |
| addr_hold | output | 20 | Address latched at the last strobe |
| cyc_kind | output | 3 | Decoded bus cycle type |
| t_state | output | 3 | Current T-state |
| seg_sel | output | 4 | One-hot active segment |
| data_valid | output | 1 | One-clock data capture pulse |
| data_byte | output | 8 | Captured data byte |

## Verification
A zero-wait code fetch checks the plain T1-T2-T3-T4-TI walk and the data capture when the cycle leaves T2.

Two READY patterns exercise the two-sample wait rule separately. In the first, READY is low on the T3-entry sample only; this alone must yield exactly one Tw. In the second, READY is high on that sample and low on the next; this yields Tw entered from the current sample and a second capture at the Tw exit.

A multi-clock low READY shows that Tw persists. A status that stays active through T4 shows that no strobe fires without a passive sample first. A passive-to-active change in mid-cycle shows that the strobe takes priority over the normal step and suppresses the data capture.

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_ad,
  input  logic [2:0]    bus_stat,
  input  logic          bus_ready,
  input  logic [1:0]    bus_seg,
  output logic          addr_strobe,
  output logic [AW-1:0] addr_hold,
  output logic [2:0]    cyc_kind,
  output logic [2:0]    t_state,
  output logic [3:0]    seg_sel,
  output logic          data_valid,
  output logic [DW-1:0] data_byte
);

  localparam logic [2:0] ST_TI = 3'd0;
  localparam logic [2:0] ST_T1 = 3'd1;
  localparam logic [2:0] ST_T2 = 3'd2;
  localparam logic [2:0] ST_T3 = 3'd3;
  localparam logic [2:0] ST_TW = 3'd4;
  localparam logic [2:0] ST_T4 = 3'd5;
  localparam logic [2:0] PASV  = 3'b111;

  logic [2:0] prev_stat;
  logic       prev_rdy;
  logic [2:0] nxt;
  logic       cap;
  logic       seg_act;

  wire start = (prev_stat == PASV) && (bus_stat != PASV);

  always_comb begin
    nxt = t_state;
    cap = 1'b0;
    if (start) begin
      nxt = ST_T1;
    end else begin
      case (t_state)
        ST_T1: nxt = ST_T2;
        ST_T2: begin
          nxt = ST_T3;
          cap = bus_ready;
        end
        ST_T3: nxt = (!bus_ready || !prev_rdy) ? ST_TW : ST_T4;
        ST_TW: if (prev_rdy) begin
          nxt = ST_T4;
          cap = 1'b1;
        end
        ST_T4: nxt = ST_TI;
        default: nxt = ST_TI;
      endcase
    end
  end

  assign seg_act = (nxt == ST_T2) || (nxt == ST_T3) || (nxt == ST_TW) || (nxt == ST_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_state     <= ST_TI;
      addr_strobe <= 1'b0;
      addr_hold   <= '0;
      cyc_kind    <= PASV;
      prev_stat   <= PASV;
      prev_rdy    <= 1'b1;
      data_valid  <= 1'b0;
      data_byte   <= '0;
      seg_sel     <= '0;
    end else begin
      t_state     <= nxt;
      addr_strobe <= start;
      if (start) addr_hold <= bus_ad;
      cyc_kind    <= bus_stat;
      prev_stat   <= bus_stat;
      prev_rdy    <= bus_ready;
      data_valid  <= cap;
      if (cap) data_byte <= bus_ad[DW-1:0];
      seg_sel     <= seg_act ? (4'b0001 << bus_seg) : 4'b0000;
    end
  end

  AST_STROBE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> (cyc_kind != PASV)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe |-> $stable(addr_hold)); // R3
  AST_T1_STEP: assert property (@(posedge clk) disable iff (rst)
    (t_state == ST_T1) |=> (t_state == ST_T2 || addr_strobe)); // R4
  AST_T3_EXIT: assert property (@(posedge clk) disable iff (rst)
    (t_state == ST_T3) |=> (t_state == ST_TW || t_state == ST_T4 || addr_strobe)); // R5
  AST_TW_EXIT: assert property (@(posedge clk) disable iff (rst)
    (t_state == ST_TW) |=> (t_state == ST_TW || t_state == ST_T4 || addr_strobe)); // R6
  AST_T4_IDLE: assert property (@(posedge clk) disable iff (rst)
    (t_state == ST_T4) |=> (t_state == ST_TI || addr_strobe)); // R7
  AST_VLD_PHASE: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (t_state == ST_T3 || t_state == ST_T4)); // R8
  AST_SEG_IDLE: assert property (@(posedge clk) disable iff (rst)
    (t_state == ST_TI || t_state == ST_T1) |-> (seg_sel == 4'b0000)); // R9

endmodule

// File: tb/sim_bus_cycle_tracker.sv
module sim_bus_cycle_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_ad = '0;
  logic [2:0]  bus_stat = 3'b111;
  logic        bus_ready = 1'b1;
  logic [1:0]  bus_seg = 2'b00;
  logic        addr_strobe;
  logic [19:0] addr_hold;
  logic [2:0]  cyc_kind;
  logic [2:0]  t_state;
  logic [3:0]  seg_sel;
  logic        data_valid;
  logic [7:0]  data_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] TI = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, TW = 3'd4, T4 = 3'd5;
  localparam logic [2:0] K_IOR = 3'b001, K_IOW = 3'b010, K_CODE = 3'b100;
  localparam logic [2:0] K_MEMR = 3'b101, K_MEMW = 3'b110, K_PASV = 3'b111;

  always #5 clk = ~clk;

  bus_cycle_tracker u0 (
    .clk(clk), .rst(rst), .bus_ad(bus_ad), .bus_stat(bus_stat),
    .bus_ready(bus_ready), .bus_seg(bus_seg), .addr_strobe(addr_strobe),
    .addr_hold(addr_hold), .cyc_kind(cyc_kind), .t_state(t_state),
    .seg_sel(seg_sel), .data_valid(data_valid), .data_byte(data_byte)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] ad, input logic [2:0] st, input logic rdy, input logic [1:0] sg);
    @(negedge clk);
    bus_ad = ad; bus_stat = st; bus_ready = rdy; bus_seg = sg;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_ts(input logic [2:0] ts, input bit stb, input bit vld, input string req);
    chk(t_state == ts, req, 32'(t_state), 32'(ts));
    chk(addr_strobe == stb, {req, " strobe"}, 32'(addr_strobe), 32'(stb));
    chk(data_valid == vld, {req, " valid"}, 32'(data_valid), 32'(vld));
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    bus_stat = K_PASV; bus_ready = 1'b1;
    @(posedge clk); #1;
    expect_ts(TI, 1'b0, 1'b0, "R1");
    chk(cyc_kind == K_PASV, "R1 kind", 32'(cyc_kind), 32'(K_PASV));
    chk(addr_hold == 20'h0, "R1 addr", 32'(addr_hold), 32'h0);
    chk(seg_sel == 4'b0, "R1 seg", 32'(seg_sel), 32'h0);
    chk(data_byte == 8'h0, "R1 data", 32'(data_byte), 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_zero_wait;
    step(20'h11111, K_PASV, 1'b1, 2'b10);
    expect_ts(TI, 1'b0, 1'b0, "R7 idle");
    step(20'h14740, K_CODE, 1'b1, 2'b10);
    expect_ts(T1, 1'b1, 1'b0, "R2 R4 strobe");
    chk(addr_hold == 20'h14740, "R3 latch", 32'(addr_hold), 32'h14740);
    chk(cyc_kind == K_CODE, "R2 kind", 32'(cyc_kind), 32'(K_CODE));
    chk(seg_sel == 4'b0000, "R9 T1 seg", 32'(seg_sel), 32'h0);
    step(20'h1FF00, K_CODE, 1'b1, 2'b10);
    expect_ts(T2, 1'b0, 1'b0, "R4 T2");
    chk(seg_sel == 4'b0100, "R9 code seg", 32'(seg_sel), 32'h4);
    step(20'h000EC, K_CODE, 1'b1, 2'b10);
    expect_ts(T3, 1'b0, 1'b1, "R8 T3 capture");
    chk(data_byte == 8'hEC, "R8 data", 32'(data_byte), 32'hEC);
    step(20'h00000, K_PASV, 1'b1, 2'b10);
    expect_ts(T4, 1'b0, 1'b0, "R5 T4");
    chk(addr_hold == 20'h14740, "R3 hold", 32'(addr_hold), 32'h14740);
    step(20'h00000, K_PASV, 1'b1, 2'b10);
    expect_ts(TI, 1'b0, 1'b0, "R7 T4 to TI");
    chk(seg_sel == 4'b0000, "R9 TI seg", 32'(seg_sel), 32'h0);
    step(20'h00000, K_PASV, 1'b1, 2'b10);
    expect_ts(TI, 1'b0, 1'b0, "R7 stay TI");
  endtask

  task automatic t_prev_low;
    step(20'h003DA, K_IOR, 1'b1, 2'b01);
    expect_ts(T1, 1'b1, 1'b0, "R4 ior strobe");
    chk(cyc_kind == K_IOR, "R2 ior kind", 32'(cyc_kind), 32'(K_IOR));
    step(20'h003DA, K_IOR, 1'b1, 2'b01);
    expect_ts(T2, 1'b0, 1'b0, "R4 ior T2");
    chk(seg_sel == 4'b0010, "R9 stack seg", 32'(seg_sel), 32'h2);
    step(20'h00033, K_IOR, 1'b0, 2'b01);
    expect_ts(T3, 1'b0, 1'b0, "R8 no capture ready low");
    step(20'h00044, K_IOR, 1'b1, 2'b01);
    expect_ts(TW, 1'b0, 1'b0, "R5 prev low wait");
    step(20'h000F7, K_PASV, 1'b1, 2'b01);
    expect_ts(T4, 1'b0, 1'b1, "R6 R8 exit Tw");
    chk(data_byte == 8'hF7, "R8 Tw data", 32'(data_byte), 32'hF7);
    step(20'h00000, K_PASV, 1'b1, 2'b01);
    expect_ts(TI, 1'b0, 1'b0, "R7 ior idle");
  endtask

  task automatic t_long_wait;
    step(20'hABCDE, K_MEMR, 1'b1, 2'b11);
    expect_ts(T1, 1'b1, 1'b0, "R4 memr strobe");
    chk(addr_hold == 20'hABCDE, "R3 new latch", 32'(addr_hold), 32'hABCDE);
    step(20'hABCDE, K_MEMR, 1'b1, 2'b11);
    chk(seg_sel == 4'b1000, "R9 data seg", 32'(seg_sel), 32'h8);
    step(20'h00011, K_MEMR, 1'b0, 2'b11);
    expect_ts(T3, 1'b0, 1'b0, "R5 memr T3");
    step(20'h00022, K_MEMR, 1'b0, 2'b11);
    expect_ts(TW, 1'b0, 1'b0, "R5 memr Tw");
    step(20'h00033, K_MEMR, 1'b0, 2'b11);
    expect_ts(TW, 1'b0, 1'b0, "R6 stay Tw");
    step(20'h00044, K_MEMR, 1'b1, 2'b11);
    expect_ts(TW, 1'b0, 1'b0, "R6 prev low stays");
    step(20'h0005A, K_MEMR, 1'b1, 2'b11);
    expect_ts(T4, 1'b0, 1'b1, "R6 leave Tw");
    chk(data_byte == 8'h5A, "R8 long data", 32'(data_byte), 32'h5A);
    step(20'h0007F, K_MEMR, 1'b1, 2'b11);
    expect_ts(TI, 1'b0, 1'b0, "R7 memr idle");
    chk(data_byte == 8'h5A, "R8 data hold", 32'(data_byte), 32'h5A);
    step(20'h12345, K_MEMR, 1'b1, 2'b11);
    expect_ts(TI, 1'b0, 1'b0, "R2 no strobe active persists");
    chk(addr_hold == 20'hABCDE, "R3 no relatch", 32'(addr_hold), 32'hABCDE);
    step(20'h00000, K_PASV, 1'b1, 2'b11);
    expect_ts(TI, 1'b0, 1'b0, "R7 passive");
  endtask

  task automatic t_late_low;
    step(20'h00100, K_MEMW, 1'b1, 2'b00);
    expect_ts(T1, 1'b1, 1'b0, "R4 memw strobe");
    chk(cyc_kind == K_MEMW, "R2 memw kind", 32'(cyc_kind), 32'(K_MEMW));
    step(20'h00100, K_MEMW, 1'b1, 2'b00);
    chk(seg_sel == 4'b0001, "R9 extra seg", 32'(seg_sel), 32'h1);
    step(20'h000A1, K_MEMW, 1'b1, 2'b00);
    expect_ts(T3, 1'b0, 1'b1, "R8 memw T3 capture");
    step(20'h000B2, K_MEMW, 1'b0, 2'b00);
    expect_ts(TW, 1'b0, 1'b0, "R5 current low wait");
    step(20'h000C3, K_MEMW, 1'b1, 2'b00);
    expect_ts(TW, 1'b0, 1'b0, "R6 prev low hold");
    step(20'h000D4, K_PASV, 1'b1, 2'b00);
    expect_ts(T4, 1'b0, 1'b1, "R6 memw exit");
    chk(data_byte == 8'hD4, "R8 memw data", 32'(data_byte), 32'hD4);
    step(20'h00000, K_PASV, 1'b1, 2'b00);
    expect_ts(TI, 1'b0, 1'b0, "R7 memw idle");
  endtask

  task automatic t_preempt;
    step(20'h22222, K_CODE, 1'b1, 2'b10);
    expect_ts(T1, 1'b1, 1'b0, "R4 first strobe");
    step(20'h000EE, K_PASV, 1'b1, 2'b10);
    expect_ts(T2, 1'b0, 1'b0, "R4 T2 passive");
    step(20'h00060, K_IOW, 1'b1, 2'b10);
    expect_ts(T1, 1'b1, 1'b0, "R4 strobe preempts");
    chk(addr_hold == 20'h00060, "R3 preempt latch", 32'(addr_hold), 32'h60);
    chk(data_byte == 8'hD4, "R8 no capture on strobe", 32'(data_byte), 32'hD4);
    chk(cyc_kind == K_IOW, "R2 iow kind", 32'(cyc_kind), 32'(K_IOW));
    step(20'h00060, K_IOW, 1'b1, 2'b10);
    expect_ts(T2, 1'b0, 1'b0, "R4 iow T2");
    step(20'h00077, K_PASV, 1'b1, 2'b10);
    expect_ts(T3, 1'b0, 1'b1, "R8 iow capture");
    step(20'h00000, K_PASV, 1'b1, 2'b10);
    expect_ts(T4, 1'b0, 1'b0, "R5 iow T4");
    step(20'h00000, K_PASV, 1'b1, 2'b10);
    expect_ts(TI, 1'b0, 1'b0, "R7 iow idle");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_zero_wait();
    t_prev_low();
    t_long_wait();
    t_late_low();
    t_preempt();
    t_reset();
    finish_run();
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule